// File: doc/BRIEF.md
# Setup and Monitor Configuration Writer

This block sits behind the byte layer of a two-wire slave and turns the bytes a host writes after the slave address into control state. It holds three sets of state: an 8-bit setup register, an 8-bit configuration register, and a monitor bank. The monitor bank holds a scan-delay byte and a 10-bit lower and a 10-bit upper threshold for each channel. Bytes arrive as a one-cycle valid strobe with data. A separate one-cycle pulse marks a stop or a repeated start.

When no monitor write is open, bit 7 of a byte selects its target: 1 means the setup register and 0 means the configuration register. A setup byte with bit 0 set opens a monitor-data window of up to 13 bytes. The first byte of the window is the scan delay. The following bytes form a bit stream, most significant bit first. For channel 0 upward, the stream carries the 10-bit lower threshold and then the 10-bit upper threshold. Only the bits that belong to the active channels are stored.

The number of active channels comes from the configuration register. In single-ended mode (bit 0 = 1) it is the 2-bit channel limit (bits 2:1) plus 1. In differential mode it is half the limit plus 1. A terminate pulse can close the window at any byte, and everything not yet overwritten keeps its value. A setup byte with bit 1 cleared returns the configuration register to its power-on value and pulses a soft-reset line to the interrupt logic.

Top module: `cfgw_top`

## Requirements
- R1: After reset: setup = 0x82, configuration = 0x01, scan delay and all thresholds = 0, soft_rst low.
- R2: With no window open, a byte with bit 7 = 1 is stored whole in the setup register on the clock edge that samples it; at no other time does the setup register change.
- R3: With no window open, a byte with bit 7 = 0 is stored whole in the configuration register.
- R4: A setup byte with bit 1 = 0 sets the configuration register to 0x01 and raises soft_rst for exactly one cycle, on the same edge. Thresholds, scan delay and the written setup value are unaffected. A setup byte with bit 1 = 1 does neither.
- R5: A setup byte with bit 0 = 1 opens a window in which each following byte is monitor data, not a setup or configuration write. The first window byte becomes scan_delay.
- R6: Window bytes 2 onward form a bit stream, most significant bit first. For channel k the stream carries lower[9:0] at stream bits 20k to 20k+9 and upper[9:0] at 20k+10 to 20k+19. On lo_thr and hi_thr, channel k occupies bits [10k+9:10k].
- R7: Active channels are limit+1 when config bit 0 = 1 and limit/2+1 when it is 0, where the limit is config bits 2:1. Stream bits beyond the active channels are ignored and leave the stored thresholds unchanged.
- R8: The window closes by itself after 13 bytes, and the next byte is again decoded by bit 7.
- R9: A terminate pulse closes the window. Data already written and data not reached both keep their values, and the next byte is decoded by bit 7.
- R10: A byte whose strobe coincides with a terminate pulse is dropped and changes no register.
- R11: conv_bipolar is high only when setup bit 2 = 1 and config bit 0 = 0; single-ended mode forces it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | One-cycle strobe for a received write byte |
| byte_data | input | 8 | Received byte |
| xfer_end | input | 1 | One-cycle pulse on stop or repeated start |
| setup_q | output | 8 | Setup register |
| config_q | output | 8 | Configuration register |
| soft_rst | output | 1 | One-cycle reset pulse to the interrupt logic |
| conv_bipolar | output | 1 | Effective bipolar conversion select |
| scan_delay | output | 8 | Monitor scan-delay byte |
| lo_thr | output | 40 | Lower thresholds, 10 bits per channel |
| hi_thr | output | 40 | Upper thresholds, 10 bits per channel |

## Verification
Every register result and the soft_rst pulse are due on the first rising edge after the cycle in which byte_vld is high, with no further pipeline stage. conv_bipolar follows the registers with no added delay. The bench drives each stimulus on a falling edge and holds it for one cycle. It compares all outputs on the next falling edge, which lies just after that single register stage. It checks soft_rst low again one falling edge later to prove the pulse lasts exactly one cycle.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;

  localparam logic [BYTE_W-1:0] SETUP_POR = 8'h82;
  localparam logic [BYTE_W-1:0] CFG_POR   = 8'h01;

  // setup field positions
  localparam int SU_MON  = 0;
  localparam int SU_KEEP = 1;
  localparam int SU_BIP  = 2;
  localparam int SU_TAG  = 7;
  // configuration field positions
  localparam int CF_SE   = 0;
  localparam int CF_LIM  = 1;

  typedef enum logic [1:0] {
    BK_NONE,
    BK_SETUP,
    BK_CONFIG,
    BK_MON
  } byte_kind_e;

  // channels covered by monitor data for a given input mode and limit
  function automatic int unsigned active_chans(input logic single_ended,
                                               input logic [SEL_W-1:0] lim,
                                               input int unsigned nch);
    int unsigned n;
    n = single_ended ? 32'(lim) + 1 : 32'(lim >> 1) + 1;
    if (n > nch) n = nch;
    return n;
  endfunction

  // stream bits that are stored for a channel count
  function automatic int unsigned live_bits(input int unsigned nact,
                                            input int unsigned tw);
    return nact * 2 * tw;
  endfunction
endpackage

// File: rtl/cfgw_classify.sv
module cfgw_classify
  import cfgw_pkg::*;
(
  input  logic       vld,
  input  logic       term,
  input  logic       tag_bit,
  input  logic       win_open,
  output byte_kind_e kind
);
  always_comb begin
    if (!vld || term)  kind = BK_NONE;
    else if (win_open) kind = BK_MON;
    else if (tag_bit)  kind = BK_SETUP;
    else               kind = BK_CONFIG;
  end
endmodule

// File: rtl/cfgw_window.sv
module cfgw_window #(
  parameter int MAXB  = 13,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_req,
  input  logic             term,
  input  logic             mon_byte,
  output logic             win_open,
  output logic [IDX_W-1:0] win_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(MAXB - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      win_idx  <= '0;
    end else if (term) begin
      win_open <= 1'b0;
      win_idx  <= '0;
    end else if (open_req) begin
      win_open <= 1'b1;
      win_idx  <= '0;
    end else if (mon_byte) begin
      if (win_idx == LAST) begin
        win_open <= 1'b0;
        win_idx  <= '0;
      end else begin
        win_idx <= win_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgw_mon_bank.sv
module cfgw_mon_bank #(
  parameter int NCH   = 4,
  parameter int TW    = 10,
  parameter int IDX_W = 4,
  parameter int LB_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        data,
  input  logic [LB_W-1:0]   live,
  output logic [7:0]        scan_delay,
  output logic [NCH*TW-1:0] lo_thr,
  output logic [NCH*TW-1:0] hi_thr
);
  localparam int SB = NCH * 2 * TW;

  // strm[p] is stream bit p, p = 0 being the first bit sent
  logic [SB-1:0] strm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 scan_delay <= '0;
    else if (wr && idx == '0)   scan_delay <= data;
  end

  for (genvar p = 0; p < SB; p++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strm[p] <= 1'b0;
      else if (wr && idx == IDX_W'(p / 8 + 1) && LB_W'(p) < live)
        strm[p] <= data[7 - (p % 8)];
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    for (genvar i = 0; i < TW; i++) begin : g_b
      assign lo_thr[k*TW + i] = strm[k*2*TW + (TW - 1 - i)];
      assign hi_thr[k*TW + i] = strm[k*2*TW + TW + (TW - 1 - i)];
    end
  end
endmodule

// File: rtl/cfgw_top.sv
module cfgw_top
  import cfgw_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int TW   = 10,
  parameter int MAXB = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              xfer_end,
  output logic [7:0]        setup_q,
  output logic [7:0]        config_q,
  output logic              soft_rst,
  output logic              conv_bipolar,
  output logic [7:0]        scan_delay,
  output logic [NCH*TW-1:0] lo_thr,
  output logic [NCH*TW-1:0] hi_thr
);
  localparam int IDX_W = $clog2(MAXB + 1);
  localparam int SB    = NCH * 2 * TW;
  localparam int LB_W  = $clog2(SB + 1);

  byte_kind_e       kind;
  logic             win_open;
  logic [IDX_W-1:0] win_idx;
  logic             setup_wr, cfg_wr, mon_wr, open_req;
  logic [LB_W-1:0]  live;

  cfgw_classify u_cls (
    .vld      (byte_vld),
    .term     (xfer_end),
    .tag_bit  (byte_data[SU_TAG]),
    .win_open (win_open),
    .kind     (kind)
  );

  assign setup_wr = (kind == BK_SETUP);
  assign cfg_wr   = (kind == BK_CONFIG);
  assign mon_wr   = (kind == BK_MON);
  assign open_req = setup_wr && byte_data[SU_MON];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q  <= SETUP_POR;
      config_q <= CFG_POR;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= 1'b0;
      if (setup_wr) begin
        setup_q <= byte_data;
        if (!byte_data[SU_KEEP]) begin
          config_q <= CFG_POR;
          soft_rst <= 1'b1;
        end
      end else if (cfg_wr) begin
        config_q <= byte_data;
      end
    end
  end

  assign live = LB_W'(live_bits(active_chans(config_q[CF_SE],
                                             config_q[CF_LIM +: SEL_W],
                                             NCH), TW));

  assign conv_bipolar = setup_q[SU_BIP] && !config_q[CF_SE];

  cfgw_window #(.MAXB(MAXB), .IDX_W(IDX_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_req (open_req),
    .term     (xfer_end),
    .mon_byte (mon_wr),
    .win_open (win_open),
    .win_idx  (win_idx)
  );

  cfgw_mon_bank #(.NCH(NCH), .TW(TW), .IDX_W(IDX_W), .LB_W(LB_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (mon_wr),
    .idx        (win_idx),
    .data       (byte_data),
    .live       (live),
    .scan_delay (scan_delay),
    .lo_thr     (lo_thr),
    .hi_thr     (hi_thr)
  );
endmodule

// File: rtl/cfgw_chk.sv
module cfgw_chk #(
  parameter int NCH   = 4,
  parameter int TW    = 10,
  parameter int MAXB  = 13,
  parameter int IDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              xfer_end,
  input logic              keep_bit,
  input logic              win_open,
  input logic [IDX_W-1:0]  win_idx,
  input logic              setup_wr,
  input logic              mon_wr,
  input logic              soft_rst,
  input logic [7:0]        setup_q,
  input logic [7:0]        config_q,
  input logic              conv_bipolar,
  input logic [7:0]        scan_delay,
  input logic [NCH*TW-1:0] lo_thr,
  input logic [NCH*TW-1:0] hi_thr
);
  // R4
  soft_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> ($past(setup_wr) && !$past(keep_bit)));

  // R4
  soft_rst_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (config_q == 8'h01));

  // R8
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (win_idx < IDX_W'(MAXB)));

  // R9
  term_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !win_open);

  // R2
  setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_wr |=> $stable(setup_q));

  // R7
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_wr |=> ($stable(lo_thr) && $stable(hi_thr) && $stable(scan_delay)));

  // R10
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && xfer_end) |-> (!setup_wr && !mon_wr));

  // R11
  se_unipolar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_q[0] |-> !conv_bipolar);
endmodule

bind cfgw_top cfgw_chk #(.NCH(NCH), .TW(TW), .MAXB(MAXB), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .byte_vld     (byte_vld),
  .xfer_end     (xfer_end),
  .keep_bit     (byte_data[1]),
  .win_open     (win_open),
  .win_idx      (win_idx),
  .setup_wr     (setup_wr),
  .mon_wr       (mon_wr),
  .soft_rst     (soft_rst),
  .setup_q      (setup_q),
  .config_q     (config_q),
  .conv_bipolar (conv_bipolar),
  .scan_delay   (scan_delay),
  .lo_thr       (lo_thr),
  .hi_thr       (hi_thr)
);

// File: tb/tb_cfgw_top.sv
`timescale 1ns/1ps
module tb_cfgw_top;
  localparam int NCH = 4;
  localparam int TW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic xfer_end = 1'b0;
  logic [7:0] setup_q, config_q, scan_delay;
  logic soft_rst, conv_bipolar;
  logic [NCH*TW-1:0] lo_thr, hi_thr;

  always #2 clk = ~clk;

  cfgw_top #(.NCH(NCH), .TW(TW), .MAXB(13)) dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .xfer_end(xfer_end), .setup_q(setup_q), .config_q(config_q),
    .soft_rst(soft_rst), .conv_bipolar(conv_bipolar), .scan_delay(scan_delay),
    .lo_thr(lo_thr), .hi_thr(hi_thr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state kept from the requirements
  logic [7:0]  e_setup = 8'h82, e_cfg = 8'h01, e_sd = 8'h00;
  logic [79:0] e_strm = '0;   // e_strm[p] = stream bit p
  bit e_pulse = 0;
  bit m_open = 0;
  int m_cnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(setup_q == e_setup, req, "setup", 32'(setup_q), 32'(e_setup));
    check(config_q == e_cfg, req, "config", 32'(config_q), 32'(e_cfg));
    check(soft_rst == e_pulse, req, "soft_rst", 32'(soft_rst), 32'(e_pulse));
    check(conv_bipolar == (e_setup[2] && !e_cfg[0]), req, "bipolar",
          32'(conv_bipolar), 32'(e_setup[2] && !e_cfg[0]));
    check(scan_delay == e_sd, req, "scan_delay", 32'(scan_delay), 32'(e_sd));
    for (int ch = 0; ch < NCH; ch++) begin
      logic [9:0] el, eh;
      for (int i = 0; i < 10; i++) begin
        el[9-i] = e_strm[ch*20 + i];
        eh[9-i] = e_strm[ch*20 + 10 + i];
      end
      check(lo_thr[ch*10 +: 10] == el, req, $sformatf("lo ch%0d", ch),
            32'(lo_thr[ch*10 +: 10]), 32'(el));
      check(hi_thr[ch*10 +: 10] == eh, req, $sformatf("hi ch%0d", ch),
            32'(hi_thr[ch*10 +: 10]), 32'(eh));
    end
  endtask

  task automatic model_byte(input logic [7:0] d);
    int nact;
    nact = e_cfg[0] ? int'(e_cfg[2:1]) + 1 : int'(e_cfg[2]) + 1;
    e_pulse = 0;
    if (m_open) begin
      if (m_cnt == 0) e_sd = d;
      else
        for (int b = 0; b < 8; b++) begin
          int pos;
          pos = (m_cnt - 1) * 8 + b;
          if (pos < nact * 20) e_strm[pos] = d[7-b];
        end
      m_cnt++;
      if (m_cnt == 13) m_open = 0;
    end else if (d[7]) begin
      e_setup = d;
      if (!d[1]) begin e_cfg = 8'h01; e_pulse = 1; end
      if (d[0]) begin m_open = 1; m_cnt = 0; end
    end else begin
      e_cfg = d;
    end
  endtask

  // one byte, optionally together with a terminate pulse; compare after
  task automatic put(input logic [7:0] d, input bit with_end, input string req);
    if (with_end) begin m_open = 0; e_pulse = 0; end
    else model_byte(d);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = d; xfer_end = with_end;
    @(negedge clk);
    byte_vld = 1'b0; xfer_end = 1'b0;
    check_all(req);
    e_pulse = 0;
  endtask

  task automatic term(input string req);
    m_open = 0;
    @(negedge clk);
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    check_all(req);
  endtask

  task automatic t_reset;
    check_all("R1");
  endtask

  task automatic t_setup_and_config;
    put(8'h86, 0, "R2");        // bipolar requested, single-ended default: R11
    put(8'h06, 0, "R3");        // differential limit 3: bipolar now live, R11
    put(8'h7A, 0, "R3");
    put(8'hC6, 0, "R2");
  endtask

  task automatic t_soft_reset;
    put(8'h06, 0, "R3");
    put(8'h84, 0, "R4");        // bit1 = 0: config back to 0x01, pulse
    @(negedge clk);
    check(soft_rst == 1'b0, "R4", "pulse width", 32'(soft_rst), 32'd0);
    put(8'h06, 0, "R3");
    put(8'h86, 0, "R4");        // bit1 = 1: nothing
  endtask

  task automatic t_full_window;
    put(8'h07, 0, "R7");        // single-ended, limit 3: four channels
    put(8'h83, 0, "R5");
    for (int j = 0; j < 13; j++) put(8'(8'h35 + 8'(j * 29)), 0, "R6");
    put(8'h20, 0, "R8");        // decoded as configuration again
    put(8'h83, 0, "R8");
  endtask

  task automatic t_diff_window;
    put(8'h06, 0, "R7");        // differential limit 3: two channels
    put(8'h83, 0, "R5");
    for (int j = 0; j < 13; j++) put(8'(8'hA1 ^ 8'(j * 17)), 0, "R7");
    put(8'h01, 0, "R7");        // single-ended limit 0: one channel
    put(8'h83, 0, "R5");
    for (int j = 0; j < 4; j++) put(8'(8'h5C + 8'(j * 41)), 0, "R7");
    term("R9");
  endtask

  task automatic t_terminate;
    put(8'h07, 0, "R3");
    put(8'h83, 0, "R5");
    put(8'h11, 0, "R5");
    put(8'hF0, 0, "R6");
    put(8'h0F, 0, "R6");
    term("R9");
    put(8'h25, 0, "R9");        // config, not monitor data
    put(8'h81, 0, "R4");        // reset plus window: one channel live
    put(8'h3C, 0, "R5");
    put(8'hFF, 0, "R7");
    put(8'hFF, 0, "R7");
    put(8'hFF, 0, "R7");
    term("R9");
  endtask

  task automatic t_collision;
    put(8'h07, 0, "R3");
    put(8'h83, 0, "R5");
    put(8'h99, 1, "R10");       // dropped, window closed
    put(8'h0B, 0, "R10");       // config
    put(8'h80, 1, "R10");       // setup byte dropped
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup_and_config();
    t_soft_reset();
    t_full_window();
    t_diff_window();
    t_terminate();
    t_collision();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule